// File: doc/BRIEF.md
# Level-Map Multicast Switching Element

This block is a single n-by-n switching element for the return side of a multistage network. It carries cache-coherence messages from memory back toward processors. Every packet header carries a compact multicast directory with one n-bit map for each tree level. All elements at a given level read the same map. The element is built for one stage, chosen by a parameter at elaboration. It takes that stage's map from each incoming header and copies the packet to every output whose bit is set.

The element holds no packet storage. One frame is one clock cycle. When live packets compete for an output, the lowest-numbered input gets it. A copy that loses is not held back. A dead duplicate of the losing packet goes out on an output that no live packet uses, and that output is flagged as a conflict. Packets that arrive already flagged dead are discarded and never take an output.

For every frame the element returns a delivery matrix that shows which outputs received a live copy from which input. The sender clears exactly those bits from its own copy of the map and sends the packet again in a later frame. It repeats this until its copy of the map is empty.

Top module: `rbm_multicast_switch`

## Requirements
- R1: While reset is held, and after it is released until the first accepted frame, every out_valid bit and every out_ack bit is 0.
- R2: An input's request mask is header bits [STAGE*NPORT + o] for o = 0..NPORT-1 within that input's header slice. Header bits of other levels have no effect on routing.
- R3: A live packet forwarded to output o appears there one clock after it is presented, with out_valid=1, out_dead=0, and its header and payload unchanged.
- R4: When several live inputs request the same output in one frame, the lowest-numbered input wins that output. Each output carries at most one live copy.
- R5: An all-ones map at the element's level sends a lone live packet to every output, and this is the only way to reach all outputs.
- R6: If some live request in a frame is not granted, every output without a live winner carries a copy of the lowest-numbered such losing input with out_valid=1 and out_dead=1. With no losing request, such outputs stay invalid.
- R7: An input presented with in_dead=1 claims no output and gets no delivery bit, so it never blocks or displaces another packet.
- R8: out_ack bit i*NPORT+o is 1 exactly when output o carries a live copy from input i in that frame. The bit is registered alongside the data.
- R9: Output registers update on the rising clock edge after the inputs are presented, which gives a latency of one frame. An input with in_valid=0 has no effect.
- R10: A sender that clears its acknowledged bits and re-sends finishes. When all NPORT inputs multicast to all outputs, the transfer completes in NPORT frames, and each bit is delivered exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | NPORT | Per-input packet present |
| in_dead | input | NPORT | Per-input conflict flag of the arriving packet |
| in_hdr | input | NPORT*NPORT*NLEVEL | Per-input header: NLEVEL maps of NPORT bits, level l at bits [l*NPORT +: NPORT] |
| in_pld | input | NPORT*PLD_W | Per-input payload |
| out_valid | output | NPORT | Per-output packet present |
| out_dead | output | NPORT | Per-output conflict flag |
| out_hdr | output | NPORT*NPORT*NLEVEL | Per-output forwarded header |
| out_pld | output | NPORT*PLD_W | Per-output forwarded payload |
| out_ack | output | NPORT*NPORT | Delivery matrix, bit i*NPORT+o set when input i reached output o live |

## Verification
Some properties are checked on every cycle. Each output carries at most one live winner. A live output always has exactly one delivery bit. A conflict-flagged or idle output has none. Dead inputs never appear in the delivery matrix, and delivery bits stay inside the stage field that was presented. Other behaviour can only be shown by the bench's sweeps against an arithmetic model: which input wins by priority, which loser is chosen for the dead duplicates, whether the forwarded header and payload are correct, whether other levels are ignored, the one-frame latency, and the re-send loop running to completion.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

  // What an output slot carries in the coming frame.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_LIVE = 2'd1,
    SLOT_DEAD = 2'd2
  } slot_kind_e;

  // Index width for a port count of at least one.
  function automatic int idx_width(input int ports);
    return (ports > 1) ? $clog2(ports) : 1;
  endfunction

endpackage

// File: rtl/rbm_level_pick.sv
// Turns each input's stage field into a request row, masked by valid and not dead.
module rbm_level_pick #(
  parameter int NPORT = 4
) (
  input  logic [NPORT-1:0]       in_valid,
  input  logic [NPORT-1:0]       in_dead,
  input  logic [NPORT*NPORT-1:0] field,
  output logic [NPORT*NPORT-1:0] req
);

  for (genvar i = 0; i < NPORT; i++) begin : g_row
    logic live;
    assign live = in_valid[i] & ~in_dead[i];
    assign req[i*NPORT +: NPORT] = field[i*NPORT +: NPORT] & {NPORT{live}};
  end

endmodule

// File: rtl/rbm_out_arbiter.sv
// Fixed priority for one output: lowest-numbered requester wins.
module rbm_out_arbiter #(
  parameter int NPORT = 4
) (
  input  logic [NPORT-1:0] want,
  output logic [NPORT-1:0] gnt
);

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (want[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rbm_xbar_select.sv
// Next-frame contents of each output: the live winner, a dead duplicate of
// the first loser, or nothing.
module rbm_xbar_select
  import rbm_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int HDR_W = 12,
  parameter int PLD_W = 8
) (
  input  logic [NPORT*NPORT-1:0] req,
  input  logic [NPORT*NPORT-1:0] gnt,
  input  logic [NPORT*HDR_W-1:0] in_hdr,
  input  logic [NPORT*PLD_W-1:0] in_pld,
  output logic [NPORT-1:0]       nxt_valid,
  output logic [NPORT-1:0]       nxt_dead,
  output logic [NPORT*HDR_W-1:0] nxt_hdr,
  output logic [NPORT*PLD_W-1:0] nxt_pld
);

  localparam int IDX_W = idx_width(NPORT);

  logic [NPORT-1:0] lost;
  logic [IDX_W-1:0] loser_idx;
  logic             any_lost;

  for (genvar i = 0; i < NPORT; i++) begin : g_lost
    assign lost[i] = |(req[i*NPORT +: NPORT] & ~gnt[i*NPORT +: NPORT]);
  end

  always_comb begin
    any_lost  = 1'b0;
    loser_idx = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (lost[i] && !any_lost) begin
        loser_idx = IDX_W'(i);
        any_lost  = 1'b1;
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    slot_kind_e       kind;
    logic [IDX_W-1:0] src;

    always_comb begin
      kind = SLOT_IDLE;
      src  = loser_idx;
      for (int i = 0; i < NPORT; i++) begin
        if (gnt[i*NPORT + o]) begin
          kind = SLOT_LIVE;
          src  = IDX_W'(i);
        end
      end
      if (kind == SLOT_IDLE && any_lost) begin
        kind = SLOT_DEAD;
      end
    end

    assign nxt_valid[o]               = (kind != SLOT_IDLE);
    assign nxt_dead[o]                = (kind == SLOT_DEAD);
    assign nxt_hdr[o*HDR_W +: HDR_W]  = in_hdr[src*HDR_W +: HDR_W];
    assign nxt_pld[o*PLD_W +: PLD_W]  = in_pld[src*PLD_W +: PLD_W];
  end

endmodule

// File: rtl/rbm_multicast_switch.sv
// One switching element of a return-path multistage network, multicasting by
// the level map that belongs to stage STAGE.
module rbm_multicast_switch #(
  parameter int NPORT  = 4,
  parameter int NLEVEL = 3,
  parameter int STAGE  = 0,
  parameter int PLD_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0]              in_dead,
  input  logic [NPORT*NPORT*NLEVEL-1:0] in_hdr,
  input  logic [NPORT*PLD_W-1:0]        in_pld,
  output logic [NPORT-1:0]              out_valid,
  output logic [NPORT-1:0]              out_dead,
  output logic [NPORT*NPORT*NLEVEL-1:0] out_hdr,
  output logic [NPORT*PLD_W-1:0]        out_pld,
  output logic [NPORT*NPORT-1:0]        out_ack
);

  localparam int HDR_W = NPORT * NLEVEL;
  localparam int FLD_LO = STAGE * NPORT;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // Stage field of every header.
  logic [NPORT*NPORT-1:0] field;
  for (genvar i = 0; i < NPORT; i++) begin : g_field
    assign field[i*NPORT +: NPORT] = in_hdr[i*HDR_W + FLD_LO +: NPORT];
  end

  logic [NPORT*NPORT-1:0] req;
  rbm_level_pick #(.NPORT(NPORT)) u_pick (
    .in_valid (in_valid),
    .in_dead  (in_dead),
    .field    (field),
    .req      (req)
  );

  // Column view of the request matrix, one arbiter per output.
  logic [NPORT*NPORT-1:0] gnt;
  for (genvar o = 0; o < NPORT; o++) begin : g_arb
    logic [NPORT-1:0] want_col;
    logic [NPORT-1:0] gnt_col;
    for (genvar i = 0; i < NPORT; i++) begin : g_bit
      assign want_col[i]       = req[i*NPORT + o];
      assign gnt[i*NPORT + o]  = gnt_col[i];
    end
    rbm_out_arbiter #(.NPORT(NPORT)) u_arb (
      .want (want_col),
      .gnt  (gnt_col)
    );
  end

  logic [NPORT-1:0]       nxt_valid;
  logic [NPORT-1:0]       nxt_dead;
  logic [NPORT*HDR_W-1:0] nxt_hdr;
  logic [NPORT*PLD_W-1:0] nxt_pld;

  rbm_xbar_select #(.NPORT(NPORT), .HDR_W(HDR_W), .PLD_W(PLD_W)) u_sel (
    .req       (req),
    .gnt       (gnt),
    .in_hdr    (in_hdr),
    .in_pld    (in_pld),
    .nxt_valid (nxt_valid),
    .nxt_dead  (nxt_dead),
    .nxt_hdr   (nxt_hdr),
    .nxt_pld   (nxt_pld)
  );

  // Frame registers.
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= '0;
      out_dead  <= '0;
      out_hdr   <= '0;
      out_pld   <= '0;
      out_ack   <= '0;
    end else begin
      out_valid <= nxt_valid;
      out_dead  <= nxt_dead;
      out_hdr   <= nxt_hdr;
      out_pld   <= nxt_pld;
      out_ack   <= gnt;
    end
  end

  // Checks on the registered frame.
  for (genvar o = 0; o < NPORT; o++) begin : g_chk_out
    logic [NPORT-1:0] ack_col;
    for (genvar i = 0; i < NPORT; i++) begin : g_c
      assign ack_col[i] = out_ack[i*NPORT + o];
    end

    assert_one_winner_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
      $onehot0(ack_col));

    assert_live_has_owner_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
      (out_valid[o] && !out_dead[o]) |-> $onehot(ack_col));

    assert_dead_unacked_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
      (out_dead[o] || !out_valid[o]) |-> (ack_col == '0));

    assert_dead_is_valid_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
      out_dead[o] |-> out_valid[o]);
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk_in
    assert_dead_input_silent_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
      (in_valid[i] && in_dead[i]) |=> (out_ack[i*NPORT +: NPORT] == '0));

    assert_ack_within_field_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
      (in_valid[i] && !in_dead[i]) |=>
        ((out_ack[i*NPORT +: NPORT] & ~$past(in_hdr[i*HDR_W + FLD_LO +: NPORT])) == '0));

    assert_idle_input_silent_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
      !in_valid[i] |=> (out_ack[i*NPORT +: NPORT] == '0));
  end

endmodule

// File: tb/rbm_multicast_switch_tb.sv
module rbm_multicast_switch_tb_top;

  localparam int NP = 4;
  localparam int NL = 3;
  localparam int ST = 2;
  localparam int PW = 8;
  localparam int HW = NP * NL;

  logic              clk;
  logic              rst_n;
  logic [NP-1:0]     in_valid;
  logic [NP-1:0]     in_dead;
  logic [NP*HW-1:0]  in_hdr;
  logic [NP*PW-1:0]  in_pld;
  logic [NP-1:0]     out_valid;
  logic [NP-1:0]     out_dead;
  logic [NP*HW-1:0]  out_hdr;
  logic [NP*PW-1:0]  out_pld;
  logic [NP*NP-1:0]  out_ack;

  int n_chk = 0;
  int n_bad = 0;

  rbm_multicast_switch #(.NPORT(NP), .NLEVEL(NL), .STAGE(ST), .PLD_W(PW)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_dead (in_dead), .in_hdr (in_hdr), .in_pld (in_pld),
    .out_valid (out_valid), .out_dead (out_dead), .out_hdr (out_hdr),
    .out_pld (out_pld), .out_ack (out_ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0] cur_map [NP];

  task automatic verdict(input bit ok, input string tag, input logic [63:0] got,
                         input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive a frame: stage field from cur_map, other levels filled from salt.
  task automatic drive(input logic [NP-1:0] v, input logic [NP-1:0] d, input logic [7:0] salt);
    in_valid = v;
    in_dead  = d;
    for (int i = 0; i < NP; i++) begin
      for (int l = 0; l < NL; l++) begin
        if (l == ST) in_hdr[i*HW + l*NP +: NP] = cur_map[i];
        else         in_hdr[i*HW + l*NP +: NP] = 4'(salt ^ 8'(i*3 + l*5) ^ 8'hA6);
      end
      in_pld[i*PW +: PW] = {2'(i), 6'(salt + 8'(i))};
    end
  endtask

  // Compare the registered frame with a model of the requirements.
  task automatic check_frame(input string ctx);
    int win [NP];
    int loser;
    logic [NP-1:0]    e_live, e_dead;
    logic [NP*NP-1:0] e_ack;
    bit ok_live, ok_dead;
    loser = -1;
    for (int o = 0; o < NP; o++) begin
      win[o] = -1;
      for (int i = NP-1; i >= 0; i--)
        if (in_valid[i] && !in_dead[i] && cur_map[i][o]) win[o] = i;
    end
    for (int i = NP-1; i >= 0; i--) begin
      bit l;
      l = 1'b0;
      for (int o = 0; o < NP; o++)
        if (in_valid[i] && !in_dead[i] && cur_map[i][o] && win[o] != i) l = 1'b1;
      if (l) loser = i;
    end
    e_ack = '0;
    ok_live = 1'b1;
    ok_dead = 1'b1;
    for (int o = 0; o < NP; o++) begin
      int src;
      e_live[o] = (win[o] >= 0);
      e_dead[o] = (win[o] < 0) && (loser >= 0);
      if (win[o] >= 0) e_ack[win[o]*NP + o] = 1'b1;
      src = (win[o] >= 0) ? win[o] : loser;
      if (src >= 0) begin
        bit same;
        same = (out_hdr[o*HW +: HW] == in_hdr[src*HW +: HW]) &&
               (out_pld[o*PW +: PW] == in_pld[src*PW +: PW]);
        if (e_live[o] && !same) ok_live = 1'b0;
        if (e_dead[o] && !same) ok_dead = 1'b0;
      end
    end
    // R3, R4: live copies, winner by priority, data unchanged
    verdict(ok_live && ((out_valid & ~out_dead) == e_live), {"R3/R4 live ", ctx},
            64'(out_valid & ~out_dead), 64'(e_live));
    // R6: dead duplicates of the first loser on free outputs
    verdict(ok_dead && ((out_valid & out_dead) == e_dead), {"R6 dead ", ctx},
            64'(out_valid & out_dead), 64'(e_dead));
    // R8: delivery matrix
    verdict(out_ack == e_ack, {"R8 ack ", ctx}, 64'(out_ack), 64'(e_ack));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < NP; i++) cur_map[i] = 4'hF;
    drive(4'hF, 4'h0, 8'h11);
    repeat (4) @(negedge clk);
    // R1: held in reset despite valid inputs
    verdict(out_valid == '0 && out_ack == '0, "R1 in reset", 64'({out_valid, out_ack}), 64'd0);
    drive(4'h0, 4'h0, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    verdict(out_valid == '0 && out_ack == '0, "R1 after release", 64'({out_valid, out_ack}), 64'd0);

    // R9: one frame latency
    cur_map[0] = 4'b0110;
    drive(4'b0001, 4'h0, 8'h21);
    #1;
    verdict(out_valid == '0, "R9 before edge", 64'(out_valid), 64'd0);
    @(negedge clk);
    verdict(out_valid == 4'b0110 && out_ack == 16'h0006, "R9 after edge",
            64'({out_valid, out_ack}), 64'({4'b0110, 16'h0006}));

    // R5: all-ones map from one input reaches every output
    cur_map[2] = 4'hF;
    drive(4'b0100, 4'h0, 8'h33);
    @(negedge clk);
    verdict(out_valid == 4'hF && out_dead == 4'h0 && out_ack == 16'h0F00, "R5 broadcast",
            64'({out_valid, out_dead, out_ack}), 64'({4'hF, 4'h0, 16'h0F00}));

    // R2: stage field empty, other levels all ones -> nothing
    cur_map[1] = 4'h0;
    drive(4'b0010, 4'h0, 8'h00);
    in_hdr[1*HW +: HW] = 12'h0FF;
    @(negedge clk);
    verdict(out_valid == '0 && out_ack == '0, "R2 other levels", 64'({out_valid, out_ack}), 64'd0);

    // R7: dead input with full map claims nothing, live input unhindered
    cur_map[0] = 4'hF;
    cur_map[3] = 4'b0001;
    drive(4'b1001, 4'b0001, 8'h44);
    @(negedge clk);
    verdict(out_valid == 4'b0001 && out_dead == '0 && out_ack == 16'h1000, "R7 dead input",
            64'({out_valid, out_dead, out_ack}), 64'({4'b0001, 4'h0, 16'h1000}));

    // Sweep 1: every combination of stage maps, all inputs live
    for (int c = 0; c < 65536; c++) begin
      for (int i = 0; i < NP; i++) cur_map[i] = 4'(c >> (i*4));
      drive(4'hF, 4'h0, 8'(c) ^ 8'(c >> 8));
      @(negedge clk);
      check_frame("sweep1");
    end

    // Sweep 2: valid/dead patterns with assorted maps (R7, R9)
    for (int vm = 0; vm < 16; vm++)
      for (int dm = 0; dm < 16; dm++)
        for (int k = 0; k < 16; k++) begin
          for (int i = 0; i < NP; i++) cur_map[i] = 4'((vm*7 + dm*3 + i*5 + k*11) % 16);
          drive(4'(vm), 4'(dm), 8'(vm*16 + k));
          @(negedge clk);
          check_frame("sweep2");
        end

    // R10: re-send loop, every input multicasting to all outputs
    begin
      logic [NP-1:0] left [NP];
      logic [NP-1:0] seen [NP];
      int frames;
      bit dup;
      dup = 1'b0;
      frames = 0;
      for (int i = 0; i < NP; i++) begin left[i] = 4'hF; seen[i] = '0; end
      while ((left[0] | left[1] | left[2] | left[3]) != '0 && frames < 16) begin
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) begin cur_map[i] = left[i]; v[i] = (left[i] != '0); end
        drive(v, 4'h0, 8'(frames));
        @(negedge clk);
        frames++;
        for (int i = 0; i < NP; i++) begin
          if ((seen[i] & out_ack[i*NP +: NP]) != '0) dup = 1'b1;
          seen[i] |= out_ack[i*NP +: NP];
          left[i] &= ~out_ack[i*NP +: NP];
        end
      end
      verdict(frames == NP && !dup, "R10 frames", 64'(frames), 64'(NP));
      verdict((seen[0] & seen[1] & seen[2] & seen[3]) == 4'hF, "R10 coverage",
              64'({seen[0], seen[1], seen[2], seen[3]}), 64'hFFFF);
    end

    drive(4'h0, 4'h0, 8'h00);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule